// File: doc/BRIEF.md
# Load-Use Stall Controller

This block sits at the front of a five-stage integer pipeline and guards the one read-after-write case that operand bypassing cannot cover. A load's data only becomes available after its memory stage. An instruction that reads the load's destination in the very next slot would need that value before it exists. The block compares the destination of the load now in the execute stage with both source fields of the instruction in decode. On a match it inserts one no-op bubble and delays everything younger by a single cycle.

The block owns the program counter, the fetch/decode register (instruction word plus its address) and the control half of the decode/execute register (control word plus destination register number). The instruction memory and the decoder stay outside. The block presents the current PC and the decode-stage instruction word. In return it takes the fetched word and the decoded control word. A stall freezes the PC and the fetch/decode register by dropping their write enables. At the same time, an all-zero control word is loaded into the decode/execute register. A zero control word writes neither the register file nor memory on its way down the pipeline, so it behaves as a no-op. In the next cycle the held instruction is decoded again and the following word is fetched again.

The controller is a two-state machine. `ST_FLOW` is the normal state. `ST_BUBBLE` marks the cycle in which a freshly injected bubble occupies the execute stage. The transitions are:
- `FLOW->BUBBLE` when the hazard is detected.
- `FLOW->FLOW` otherwise.
- `BUBBLE->FLOW` unconditionally. The bubble's zero control word clears the load flag, so no second stall can follow from the same load.

Top module: `lu_stall_unit`

## Requirements
- R1: While reset is asserted and right after it, the PC is 0, the fetch/decode instruction and address are 0, and the execute-stage control word is 0.
- R2: When its write enable is high, the PC advances by 4 at each clock. The fetch/decode register takes the fetched word together with the PC it was fetched from.
- R3: A stall is raised, and both PC and fetch/decode write enables are driven low, exactly when two conditions hold. First, the execute-stage control word has its memory-read flag (bit 1) set. Second, the execute-stage destination number equals the decode instruction's first source field (bits 25:21) or its second source field (bits 20:16).
- R4: During a stall the PC, the fetch/decode instruction and its address keep their values across the clock edge.
- R5: The control word offered to the decode/execute register is all zero during a stall. Otherwise it equals the decoded control word, and it appears in the execute stage one clock later.
- R6: A producer without the memory-read flag never causes a stall, even when its destination matches a source of the decode instruction.
- R7: A stall lasts exactly one cycle. The cycle after a stall has no stall, and the held instruction is decoded again in it.
- R8: The decode/execute register is loaded on every clock, stall or not, so the load leaves the execute stage while the bubble enters it.
- R9: A load followed immediately by a dependent instruction costs exactly one extra cycle. Two chained dependent loads cost two. Independent code, including a dependent use two slots after the load, costs none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_instr | input | 32 | Instruction word read at address `pc_q` |
| dec_ctrl | input | 8 | Control word decoded from `ifid_instr`; bit 1 is memory read |
| pc_q | output | 32 | Current program counter |
| pc_we | output | 1 | PC write enable, low on a stall |
| ifid_we | output | 1 | Fetch/decode register write enable, low on a stall |
| ifid_instr | output | 32 | Instruction word held in the decode stage |
| ifid_pc | output | 32 | Address of the decode-stage instruction |
| idex_ctrl_d | output | 8 | Control word entering the decode/execute register |
| ex_ctrl | output | 8 | Control word held in the execute stage |
| ex_rt | output | 5 | Destination number held in the execute stage |

## Verification
Two actions can coincide in the same cycle: holding the front end and handing the load onward while a bubble replaces it in the execute stage. Both must happen at the same edge, or the load would be lost or issued twice. The bench provokes this with loads followed by a dependent use in either source field, and with two chained dependent loads that stall twice in a row. A behavioural reference model tracks PC, decode and execute contents at every clock, and the counted stall cycles and final PC are compared with the cost each program should incur.

// File: rtl/lu_pkg.sv
package lu_pkg;
    typedef enum logic [0:0] {
        ST_FLOW   = 1'b0,
        ST_BUBBLE = 1'b1
    } lu_state_t;
endpackage

// File: rtl/lu_pc_reg.sv
module lu_pc_reg #(
    parameter int XLEN = 32,
    parameter int STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    output logic [XLEN-1:0] pc
);
    localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  pc <= '0;
        else if (we) pc <= pc + STEP_V;
    end
endmodule

// File: rtl/lu_fd_reg.sv
module lu_fd_reg #(
    parameter int XLEN = 32,
    parameter int IW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IW-1:0]   instr_in,
    input  logic [XLEN-1:0] pc_in,
    output logic [IW-1:0]   instr_q,
    output logic [XLEN-1:0] pc_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            instr_q <= '0;
            pc_q    <= '0;
        end else if (we) begin
            instr_q <= instr_in;
            pc_q    <= pc_in;
        end
    end
endmodule

// File: rtl/lu_dx_reg.sv
module lu_dx_reg #(
    parameter int CW = 8,
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] ctrl_in,
    input  logic [RW-1:0] rt_in,
    output logic [CW-1:0] ctrl_q,
    output logic [RW-1:0] rt_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            rt_q   <= '0;
        end else begin
            ctrl_q <= ctrl_in;
            rt_q   <= rt_in;
        end
    end
endmodule

// File: rtl/lu_hazard_fsm.sv
module lu_hazard_fsm
    import lu_pkg::*;
#(
    parameter int CW = 8,
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ex_mem_read,
    input  logic [RW-1:0] ex_rt,
    input  logic [RW-1:0] dec_rs,
    input  logic [RW-1:0] dec_rt,
    input  logic [CW-1:0] dec_ctrl,
    output logic          pc_we,
    output logic          ifid_we,
    output logic [CW-1:0] dx_ctrl
);
    lu_state_t state, state_nx;
    logic      hazard;

    assign hazard = ex_mem_read && ((ex_rt == dec_rs) || (ex_rt == dec_rt));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FLOW;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FLOW:   state_nx = hazard ? ST_BUBBLE : ST_FLOW;
            ST_BUBBLE: state_nx = ST_FLOW;
            default:   state_nx = ST_FLOW;
        endcase
    end

    always_comb begin
        pc_we   = !hazard;
        ifid_we = !hazard;
        dx_ctrl = hazard ? '0 : dec_ctrl;
    end

    // R7: a bubble in execute carries a zero control word, so no repeat stall
    assert_single_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUBBLE) |-> !hazard);

    // R6: without a memory read in execute there is never a stall
    assert_nonload_no_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_mem_read |-> (pc_we && ifid_we));
endmodule

// File: rtl/lu_stall_unit.sv
module lu_stall_unit #(
    parameter int XLEN    = 32,
    parameter int IW      = 32,
    parameter int CW      = 8,
    parameter int RW      = 5,
    parameter int MR_BIT  = 1,
    parameter int RS_LSB  = 21,
    parameter int RT_LSB  = 16,
    parameter int PC_STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IW-1:0]   fetch_instr,
    input  logic [CW-1:0]   dec_ctrl,
    output logic [XLEN-1:0] pc_q,
    output logic            pc_we,
    output logic            ifid_we,
    output logic [IW-1:0]   ifid_instr,
    output logic [XLEN-1:0] ifid_pc,
    output logic [CW-1:0]   idex_ctrl_d,
    output logic [CW-1:0]   ex_ctrl,
    output logic [RW-1:0]   ex_rt
);
    localparam int RS_MSB = RS_LSB + RW - 1;
    localparam int RT_MSB = RT_LSB + RW - 1;

    logic [RW-1:0] dec_rs, dec_rt;
    assign dec_rs = ifid_instr[RS_MSB:RS_LSB];
    assign dec_rt = ifid_instr[RT_MSB:RT_LSB];

    lu_pc_reg #(.XLEN(XLEN), .STEP(PC_STEP)) u_pc (
        .clk(clk), .rst_n(rst_n), .we(pc_we), .pc(pc_q)
    );

    lu_fd_reg #(.XLEN(XLEN), .IW(IW)) u_fd (
        .clk(clk), .rst_n(rst_n), .we(ifid_we),
        .instr_in(fetch_instr), .pc_in(pc_q),
        .instr_q(ifid_instr), .pc_q(ifid_pc)
    );

    lu_hazard_fsm #(.CW(CW), .RW(RW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ex_mem_read(ex_ctrl[MR_BIT]), .ex_rt(ex_rt),
        .dec_rs(dec_rs), .dec_rt(dec_rt), .dec_ctrl(dec_ctrl),
        .pc_we(pc_we), .ifid_we(ifid_we), .dx_ctrl(idex_ctrl_d)
    );

    lu_dx_reg #(.CW(CW), .RW(RW)) u_dx (
        .clk(clk), .rst_n(rst_n),
        .ctrl_in(idex_ctrl_d), .rt_in(dec_rt),
        .ctrl_q(ex_ctrl), .rt_q(ex_rt)
    );

    // R4: a stall holds PC and the fetch/decode register
    assert_stall_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_we |=> ($stable(pc_q) && $stable(ifid_instr) && $stable(ifid_pc)));

    // R2: an enabled PC steps by the configured increment
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |=> (pc_q == $past(pc_q) + XLEN'(PC_STEP)));

    // R5: a stall puts a zero control word into execute on the next cycle
    assert_bubble_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ifid_we |=> (ex_ctrl == '0));

    // R3: a stall only follows a memory read whose destination feeds decode
    assert_stall_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_we |-> (ex_ctrl[MR_BIT] && ((ex_rt == dec_rs) || (ex_rt == dec_rt))));
endmodule

// File: tb/sim_lu_stall_unit.sv
module sim_lu_stall_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_instr;
    logic [7:0]  dec_ctrl;
    logic [31:0] pc_q, ifid_instr, ifid_pc;
    logic        pc_we, ifid_we;
    logic [7:0]  idex_ctrl_d, ex_ctrl;
    logic [4:0]  ex_rt;

    int checks = 0;
    int failures = 0;
    int prog = 0;

    always #2.5 clk = ~clk;

    lu_stall_unit u0 (
        .clk(clk), .rst_n(rst_n), .fetch_instr(fetch_instr), .dec_ctrl(dec_ctrl),
        .pc_q(pc_q), .pc_we(pc_we), .ifid_we(ifid_we), .ifid_instr(ifid_instr),
        .ifid_pc(ifid_pc), .idex_ctrl_d(idex_ctrl_d), .ex_ctrl(ex_ctrl), .ex_rt(ex_rt)
    );

    function automatic logic [31:0] enc_lw(input int base, input int dst);
        return {6'h23, 5'(base), 5'(dst), 16'h0000};
    endfunction

    function automatic logic [31:0] enc_add(input int dst, input int a, input int b);
        return {6'h00, 5'(a), 5'(b), 5'(dst), 5'd0, 6'h20};
    endfunction

    function automatic logic [31:0] imem(input int p, input logic [31:0] addr);
        int idx = int'(addr >> 2);
        case (p)
            0: case (idx) 0: return enc_lw(1, 2); 1: return enc_add(5, 3, 4);
                          2: return enc_add(6, 7, 8); default: return 32'h0; endcase
            1: case (idx) 0: return enc_lw(1, 2); 1: return enc_add(4, 2, 3);
                          2: return enc_add(6, 7, 8); default: return 32'h0; endcase
            2: case (idx) 0: return enc_lw(1, 2); 1: return enc_add(4, 3, 2);
                          2: return enc_add(6, 7, 8); default: return 32'h0; endcase
            3: case (idx) 0: return enc_add(2, 1, 1); 1: return enc_add(4, 2, 3);
                          default: return 32'h0; endcase
            4: case (idx) 0: return enc_lw(1, 2); 1: return enc_add(5, 6, 7);
                          2: return enc_add(4, 2, 3); default: return 32'h0; endcase
            default: case (idx) 0: return enc_lw(1, 2); 1: return enc_lw(2, 3);
                          2: return enc_add(4, 3, 5); default: return 32'h0; endcase
        endcase
    endfunction

    // external decoder: bit0 reg write, bit1 memory read, bit4/bit5 ALU select
    function automatic logic [7:0] decode(input logic [31:0] w);
        if (w == 32'h0)            return 8'h00;
        else if (w[31:26] == 6'h23) return 8'h13;
        else                        return 8'h21;
    endfunction

    assign fetch_instr = imem(prog, pc_q);
    assign dec_ctrl    = decode(ifid_instr);

    // reference model state (values after the most recent clock edge)
    logic [31:0] m_pc, m_ifid, m_ifid_pc;
    logic [7:0]  m_ex_ctrl;
    logic [4:0]  m_ex_rt;
    bit          prev_stall;
    logic [31:0] prev_ifid;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_cycle(output bit stall);
        logic       haz;
        logic [7:0] dctl;
        haz = m_ex_ctrl[1] && ((m_ex_rt == m_ifid[25:21]) || (m_ex_rt == m_ifid[20:16]));
        dctl = decode(m_ifid);
        check("R2", "pc_q", pc_q, m_pc);
        check("R2", "ifid_instr", ifid_instr, m_ifid);
        check("R2", "ifid_pc", ifid_pc, m_ifid_pc);
        check("R3", "pc_we", 32'(pc_we), 32'(!haz));
        check("R3", "ifid_we", 32'(ifid_we), 32'(!haz));
        check("R5", "idex_ctrl_d", 32'(idex_ctrl_d), haz ? 32'h0 : 32'(dctl));
        check("R8", "ex_ctrl", 32'(ex_ctrl), 32'(m_ex_ctrl));
        check("R8", "ex_rt", 32'(ex_rt), 32'(m_ex_rt));
        if (prev_stall) begin
            check("R7", "no stall after stall", 32'(pc_we), 32'h1);
            check("R7", "held instr redecoded", ifid_instr, prev_ifid);
        end
        prev_stall = haz;
        prev_ifid  = m_ifid;
        stall = haz;
        // advance model to the next edge
        m_ex_ctrl = haz ? 8'h00 : dctl;
        m_ex_rt   = m_ifid[20:16];
        if (!haz) begin
            m_ifid    = imem(prog, m_pc);
            m_ifid_pc = m_pc;
            m_pc      = m_pc + 32'd4;
        end
    endtask

    task automatic run_prog(input int p, input int exp_stalls, input string tag);
        int stalls = 0;
        bit st;
        rst_n = 1'b0;
        prog = p;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", "reset pc", pc_q, 32'h0);
        check("R1", "reset ifid", ifid_instr, 32'h0);
        check("R1", "reset ex_ctrl", 32'(ex_ctrl), 32'h0);
        rst_n = 1'b1;
        m_pc = 0; m_ifid = 0; m_ifid_pc = 0; m_ex_ctrl = 0; m_ex_rt = 0;
        prev_stall = 0; prev_ifid = 0;
        for (int i = 0; i < 12; i++) begin
            compare_cycle(st);
            if (!pc_we) stalls++;
            @(negedge clk);
        end
        check(tag, "stall cycles", 32'(stalls), 32'(exp_stalls));
        check("R9", "final pc", pc_q, 32'(4 * (12 - exp_stalls)));
    endtask

    initial begin
        #(5ns * 5000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        run_prog(0, 0, "R9");  // independent after load
        run_prog(1, 1, "R3");  // dependent via first source
        run_prog(2, 1, "R3");  // dependent via second source
        run_prog(3, 0, "R6");  // non-load producer
        run_prog(4, 0, "R9");  // use two slots after load
        run_prog(5, 2, "R7");  // chained dependent loads
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule